// File: doc/BRIEF.md
# Paged MDIO Register Access Bridge

This block turns register reads and writes aimed at a flat switch register space into short sequences of clause-22 style MDIO register operations. A requester presents a byte address, write data, an access size (one 16-bit half or a full 32-bit word) and a direction. The bridge derives three fields from the address: a page, a PHY sub-address and a register index. It then runs the matching downstream operations and acknowledges with the read data and an error flag.

The bridge keeps a copy of the page that was last selected. When a request needs a different page, it first writes the new page number to a fixed page-select register and waits a settling time before any data operation starts. A full word always takes two 16-bit operations at two consecutive register indices. For writes, a configuration input chooses which half goes first. Driving the MDC/MDIO wire is left to a separate engine behind the downstream valid/ready interface.

The settling time is a clock-cycle count derived from the clock frequency and a time in microseconds, both parameters, so a test build can shorten it.

Top module: `mdio_page_bridge`

## Requirements
- R1: A data operation targets PHY address 0x10 OR address bits [8:6], and the register index is taken from address bits [5:1] (bit 1 also picks the 16-bit half).
- R2: A page change is one MDIO write to PHY 0x18, register 0, with the page (address bits [17:9]) in data bits [8:0] and zeros in bits [15:9].
- R3: The page-select write is issued only when the request's page differs from the held page. After reset no page is held, so the first request always writes the page select, even for page 0.
- R4: After a page-select write completes, no data operation is offered until at least SETTLE_CYCLES clock cycles have passed, where SETTLE_CYCLES = CLK_HZ/1e6 × SETTLE_US.
- R5: A 32-bit read reads register index reg and then reg+1, and returns {data from reg+1, data from reg}, whatever cfg_lo_first is set to.
- R6: A 32-bit write with cfg_lo_first=1 writes wdata[15:0] to reg and then wdata[31:16] to reg+1.
- R7: A 32-bit write with cfg_lo_first=0 writes wdata[31:16] to reg+1 and then wdata[15:0] to reg.
- R8: A 16-bit access is a single operation at reg. With address bit 1 = 1 it uses bus bits [31:16] for write data and returns read data in [31:16] with [15:0] zero. With bit 1 = 0 it uses bits [15:0] and returns [31:16] as zero.
- R9: While op_valid is high and op_ready is low, op_phy, op_reg, op_write and op_wdata stay unchanged.
- R10: req_err at the acknowledge is the OR of op_err over every operation of that request, page write included. It starts clear for each new request.
- R11: req_ack is a one-cycle pulse, and op_valid is low while req_ack is high.
- R12: After reset, req_ack and op_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_lo_first | input | 1 | 1: a word write sends the low half first; 0: the high half first |
| req_valid | input | 1 | Request present; held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_addr | input | 17 | Byte address bits [17:1] |
| req_wdata | input | 32 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, valid with req_ack |
| req_err | output | 1 | Error flag of the request, valid with req_ack |
| op_valid | output | 1 | Downstream operation offered |
| op_write | output | 1 | Downstream operation is a write |
| op_phy | output | 5 | Downstream PHY address |
| op_reg | output | 5 | Downstream register index |
| op_wdata | output | 16 | Downstream write data |
| op_ready | input | 1 | Downstream accepts; the operation completes in this cycle |
| op_rdata | input | 16 | Downstream read data, sampled at completion |
| op_err | input | 1 | Downstream error, sampled at completion |

## Verification
The hardest case to reach is the gap between a page-select write and the next data operation. It only appears on a page change, and at the default setting it lasts a quarter of a million cycles. The bench shortens it through the microsecond parameter, answers the page write with no wait, and counts cycles to the first data offer. A second hard case is an error on one particular operation inside a multi-operation request. The bench's downstream model can raise op_err on a chosen operation index and add a programmable ready latency, which also holds operations open for the stability rule.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  localparam int HALF_W   = 16;
  localparam int WORD_W   = 32;
  localparam int PHY_W    = 5;
  localparam int REG_W    = 5;
  localparam int SUB_W    = 3;
  localparam int PAGE_W   = 9;
  localparam int REG_LSB  = 1;
  localparam int SUB_LSB  = REG_LSB + REG_W;
  localparam int PAGE_LSB = SUB_LSB + SUB_W;
  localparam int ADDR_MSB = PAGE_LSB + PAGE_W - 1;

  localparam logic [PHY_W-1:0] PAGE_SEL_PHY  = 5'h18;
  localparam logic [PHY_W-1:0] DATA_PHY_BASE = 5'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PAGE, ST_SETTLE, ST_OP1, ST_OP2, ST_DONE
  } mpb_state_e;
endpackage

// File: rtl/mpb_settle_timer.sv
module mpb_settle_timer #(
  parameter int unsigned CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? CNT_W'(CYCLES) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0) && !start;
endmodule

// File: rtl/mpb_page_cache.sv
module mpb_page_cache
  import mpb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [PAGE_W-1:0] probe,
  output logic              hit
);
  logic              valid_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    valid_q <= 1'b0;
    else if (load) valid_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    page_q <= '0;
    else if (load) page_q <= page_in;
  end

  assign hit = valid_q && (page_q == probe);
endmodule

// File: rtl/mpb_op_plan.sv
module mpb_op_plan
  import mpb_pkg::*;
(
  input  logic              step,      // 0 = first operation, 1 = second
  input  logic              wide,
  input  logic              write,
  input  logic              lo_first,
  input  logic              lane,      // address bit 1
  input  logic [REG_W-1:0]  reg_base,
  input  logic [WORD_W-1:0] wdata,
  output logic [REG_W-1:0]  reg_idx,
  output logic [HALF_W-1:0] wdata16,
  output logic              hi_half
);
  logic first_hi;

  always_comb begin
    // only a word write with the high-first setting starts on the upper half
    first_hi = write && !lo_first;
    if (wide) hi_half = step ? !first_hi : first_hi;
    else      hi_half = lane;
    reg_idx = (wide && hi_half) ? REG_W'(reg_base + 1'b1) : reg_base;
    wdata16 = hi_half ? wdata[WORD_W-1:HALF_W] : wdata[HALF_W-1:0];
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mpb_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125000000,
  parameter int unsigned SETTLE_US = 2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_lo_first,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [ADDR_MSB:1]   req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                req_ack,
  output logic [WORD_W-1:0]   req_rdata,
  output logic                req_err,
  output logic                op_valid,
  output logic                op_write,
  output logic [PHY_W-1:0]    op_phy,
  output logic [REG_W-1:0]    op_reg,
  output logic [HALF_W-1:0]   op_wdata,
  input  logic                op_ready,
  input  logic [HALF_W-1:0]   op_rdata,
  input  logic                op_err
);
  localparam int unsigned SETTLE_CYCLES = (CLK_HZ / 1000000) * SETTLE_US;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mpb_state_e state_q, state_d;

  logic              wr_q, wide_q, lof_q, lane_q;
  logic [PAGE_W-1:0] pg_q;
  logic [SUB_W-1:0]  sub_q;
  logic [REG_W-1:0]  reg_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;

  logic capture, hs, page_hs, data_rd_hs, rdata_en, err_en;
  logic hit, settle_done;
  logic [REG_W-1:0]  plan_reg;
  logic [HALF_W-1:0] plan_wdata;
  logic              plan_hi;

  assign capture    = (state_q == ST_IDLE) && req_valid;
  assign op_valid   = (state_q == ST_PAGE) || (state_q == ST_OP1) || (state_q == ST_OP2);
  assign hs         = op_valid && op_ready;
  assign page_hs    = hs && (state_q == ST_PAGE);
  assign data_rd_hs = hs && (state_q != ST_PAGE) && !wr_q;

  mpb_page_cache u_cache (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .load    (page_hs),
    .page_in (pg_q),
    .probe   (req_addr[ADDR_MSB:PAGE_LSB]),
    .hit     (hit)
  );

  mpb_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (page_hs),
    .done  (settle_done)
  );

  mpb_op_plan u_plan (
    .step     (state_q == ST_OP2),
    .wide     (wide_q),
    .write    (wr_q),
    .lo_first (lof_q),
    .lane     (lane_q),
    .reg_base (reg_q),
    .wdata    (wdata_q),
    .reg_idx  (plan_reg),
    .wdata16  (plan_wdata),
    .hi_half  (plan_hi)
  );

  // downstream operation fields
  always_comb begin
    if (state_q == ST_PAGE) begin
      op_phy   = PAGE_SEL_PHY;
      op_reg   = '0;
      op_wdata = {{(HALF_W-PAGE_W){1'b0}}, pg_q};
      op_write = 1'b1;
    end else begin
      op_phy   = DATA_PHY_BASE | {{(PHY_W-SUB_W){1'b0}}, sub_q};
      op_reg   = plan_reg;
      op_wdata = plan_wdata;
      op_write = wr_q;
    end
  end

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid)   state_d = hit ? ST_OP1 : ST_PAGE;
      ST_PAGE:   if (hs)          state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_OP1;
      ST_OP1:    if (hs)          state_d = wide_q ? ST_OP2 : ST_DONE;
      ST_OP2:    if (hs)          state_d = ST_DONE;
      ST_DONE:                    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  // response data and error
  always_comb begin
    rdata_en = capture || data_rd_hs;
    err_en   = capture || hs;
    if (capture)      rdata_d = '0;
    else if (plan_hi) rdata_d = {op_rdata, rdata_q[HALF_W-1:0]};
    else              rdata_d = {rdata_q[WORD_W-1:HALF_W], op_rdata};
    err_d = capture ? 1'b0 : (err_q | op_err);
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      lof_q   <= 1'b0;
      lane_q  <= 1'b0;
      pg_q    <= '0;
      sub_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else if (capture) begin
      wr_q    <= req_write;
      wide_q  <= req_wide;
      lof_q   <= cfg_lo_first;
      lane_q  <= req_addr[REG_LSB];
      pg_q    <= req_addr[ADDR_MSB:PAGE_LSB];
      sub_q   <= req_addr[PAGE_LSB-1:SUB_LSB];
      reg_q   <= req_addr[SUB_LSB-1:REG_LSB];
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)   rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign req_ack   = (state_q == ST_DONE);
  assign req_rdata = rdata_q;
  assign req_err   = err_q;
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker
  import mpb_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 250000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ack,
  input logic              op_valid,
  input logic              op_ready,
  input logic              op_write,
  input logic [PHY_W-1:0]  op_phy,
  input logic [REG_W-1:0]  op_reg,
  input logic [HALF_W-1:0] op_wdata
);
  localparam int GAP_W = $clog2(SETTLE_CYCLES + 1);

  logic             armed_q;
  logic [GAP_W-1:0] gap_q;
  logic             page_done, data_offer;

  assign page_done  = op_valid && op_ready && (op_phy == PAGE_SEL_PHY);
  assign data_offer = op_valid && (op_phy != PAGE_SEL_PHY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      armed_q <= 1'b0;
    else if (page_done)              armed_q <= 1'b1;
    else if (data_offer && op_ready) armed_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               gap_q <= '0;
    else if (page_done)                       gap_q <= '0;
    else if (gap_q != GAP_W'(SETTLE_CYCLES))  gap_q <= gap_q + 1'b1;
  end

  // R9
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable({op_phy, op_reg, op_wdata, op_write}));

  // R2
  a_r2_page_target: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_phy == PAGE_SEL_PHY) |-> (op_reg == '0) && op_write
                                            && (op_wdata[HALF_W-1:PAGE_W] == '0));

  // R1
  a_r1_data_phy: assert property (@(posedge clk) disable iff (!rst_n)
    data_offer |-> (op_phy[PHY_W-1:SUB_W] == 2'b10));

  // R4
  a_r4_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && data_offer |-> (gap_q >= GAP_W'(SETTLE_CYCLES)));

  // R11
  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  // R11
  a_r11_no_op_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !op_valid);
endmodule

bind mdio_page_bridge mpb_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_q),
  .req_ack  (req_ack),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_write (op_write),
  .op_phy   (op_phy),
  .op_reg   (op_reg),
  .op_wdata (op_wdata)
);

// File: tb/sim_mdio_page_bridge.sv
module sim_mdio_page_bridge;
  localparam int unsigned CLK_HZ    = 125000000;
  localparam int unsigned SETTLE_US = 1;
  localparam int unsigned N_SETTLE  = (CLK_HZ / 1000000) * SETTLE_US;

  logic        clk, rst_n, cfg_lo_first;
  logic        req_valid, req_write, req_wide;
  logic [17:1] req_addr;
  logic [31:0] req_wdata, req_rdata;
  logic        req_ack, req_err;
  logic        op_valid, op_write, op_ready, op_err;
  logic [4:0]  op_phy, op_reg;
  logic [15:0] op_wdata, op_rdata;

  mdio_page_bridge #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_lo_first(cfg_lo_first),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .req_rdata(req_rdata), .req_err(req_err),
    .op_valid(op_valid), .op_write(op_write), .op_phy(op_phy), .op_reg(op_reg),
    .op_wdata(op_wdata), .op_ready(op_ready), .op_rdata(op_rdata), .op_err(op_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // downstream model
  int          lat = 0;
  int          inj_err_idx = -1;
  int          wcnt = 0;
  int          log_n = 0;
  logic [4:0]  log_phy [8];
  logic [4:0]  log_reg [8];
  logic        log_wr  [8];
  logic [15:0] log_wd  [8];
  int          log_cyc [8];

  function automatic logic [15:0] rd_model(input logic [4:0] p, input logic [4:0] r);
    return {3'b101, p, r, 3'b011};
  endfunction

  initial begin
    op_ready = 1'b0;
    op_rdata = '0;
    op_err   = 1'b0;
  end

  always @(negedge clk) begin
    if (!op_valid) begin
      op_ready = 1'b0;
      op_err   = 1'b0;
      wcnt     = 0;
    end else if (wcnt >= lat) begin
      op_ready = 1'b1;
      op_rdata = rd_model(op_phy, op_reg);
      op_err   = (log_n == inj_err_idx);
      if (log_n < 8) begin
        log_phy[log_n] = op_phy;
        log_reg[log_n] = op_reg;
        log_wr[log_n]  = op_write;
        log_wd[log_n]  = op_wdata;
        log_cyc[log_n] = cyc;
      end
      log_n = log_n + 1;
      wcnt  = 0;
    end else begin
      op_ready = 1'b0;
      op_err   = 1'b0;
      wcnt     = wcnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compares phy, reg, direction and (for writes) data of a logged operation
  task automatic chk_op(input string tag, input int i, input logic [4:0] p,
                        input logic [4:0] r, input logic w, input logic [15:0] d);
    logic [31:0] act, exp;
    act = {5'b0, log_phy[i], log_reg[i], log_wr[i], (w ? log_wd[i] : 16'h0)};
    exp = {5'b0, p, r, w, (w ? d : 16'h0)};
    chk(tag, act, exp);
  endtask

  function automatic logic [17:0] mkaddr(input logic [8:0] pg, input logic [2:0] sub,
                                         input logic [4:0] r);
    return {pg, sub, r, 1'b0};
  endfunction

  logic [31:0] got_rdata;
  logic        got_err, ack_op_valid, ack_after;

  task automatic do_req(input logic w, input logic wide, input logic [17:0] a,
                        input logic [31:0] d);
    log_n = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_wide  = wide;
    req_addr  = a[17:1];
    req_wdata = d;
    do @(negedge clk); while (!req_ack);
    got_rdata    = req_rdata;
    got_err      = req_err;
    ack_op_valid = op_valid;
    req_valid    = 1'b0;
    @(negedge clk);
    ack_after = req_ack;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 ack after reset", {31'b0, req_ack}, 32'h0);
    chk("R12 op_valid after reset", {31'b0, op_valid}, 32'h0);
  endtask

  task automatic t_first_read_page0();
    lat = 1; cfg_lo_first = 1'b1;
    do_req(1'b0, 1'b1, mkaddr(9'd0, 3'd2, 5'd4), 32'h0);
    chk("R3 first access pages even page 0", log_n, 3);
    chk_op("R2 page select op", 0, 5'h18, 5'd0, 1'b1, 16'h0000);
    chk_op("R1 R5 low half op", 1, 5'h12, 5'd4, 1'b0, 16'h0);
    chk_op("R5 high half op", 2, 5'h12, 5'd5, 1'b0, 16'h0);
    chk("R5 word read data", got_rdata, {rd_model(5'h12, 5'd5), rd_model(5'h12, 5'd4)});
    chk("R10 no error", {31'b0, got_err}, 32'h0);
  endtask

  task automatic t_same_page();
    do_req(1'b0, 1'b1, mkaddr(9'd0, 3'd5, 5'd10), 32'h0);
    chk("R3 same page no page write", log_n, 2);
    chk_op("R1 sub-address 5", 0, 5'h15, 5'd10, 1'b0, 16'h0);
  endtask

  task automatic t_wr_lo_first();
    lat = 2; cfg_lo_first = 1'b1;
    do_req(1'b1, 1'b1, mkaddr(9'd3, 3'd1, 5'd6), 32'hA5A5_1234);
    chk("R3 page change writes page", log_n, 3);
    chk_op("R2 page value 3", 0, 5'h18, 5'd0, 1'b1, 16'h0003);
    chk_op("R6 R9 lo first op", 1, 5'h11, 5'd6, 1'b1, 16'h1234);
    chk_op("R6 hi second op", 2, 5'h11, 5'd7, 1'b1, 16'hA5A5);
  endtask

  task automatic t_wr_hi_first();
    lat = 1; cfg_lo_first = 1'b0;
    do_req(1'b1, 1'b1, mkaddr(9'd3, 3'd1, 5'd8), 32'hDEAD_BEEF);
    chk("R7 two ops", log_n, 2);
    chk_op("R7 hi first op", 0, 5'h11, 5'd9, 1'b1, 16'hDEAD);
    chk_op("R7 lo second op", 1, 5'h11, 5'd8, 1'b1, 16'hBEEF);
    do_req(1'b0, 1'b1, mkaddr(9'd3, 3'd0, 5'd2), 32'h0);
    chk_op("R5 read lo first regardless", 0, 5'h10, 5'd2, 1'b0, 16'h0);
    chk("R5 read data hi-first cfg", got_rdata, {rd_model(5'h10, 5'd3), rd_model(5'h10, 5'd2)});
    cfg_lo_first = 1'b1;
  endtask

  task automatic t_narrow();
    lat = 0;
    do_req(1'b1, 1'b0, mkaddr(9'd3, 3'd3, 5'd11), 32'h7788_99AA);
    chk("R8 narrow single op", log_n, 1);
    chk_op("R8 upper lane write", 0, 5'h13, 5'd11, 1'b1, 16'h7788);
    do_req(1'b1, 1'b0, mkaddr(9'd3, 3'd3, 5'd12), 32'h7788_99AA);
    chk_op("R8 lower lane write", 0, 5'h13, 5'd12, 1'b1, 16'h99AA);
    do_req(1'b0, 1'b0, mkaddr(9'd3, 3'd3, 5'd11), 32'h0);
    chk("R8 upper lane read", got_rdata, {rd_model(5'h13, 5'd11), 16'h0});
    do_req(1'b0, 1'b0, mkaddr(9'd3, 3'd3, 5'd12), 32'h0);
    chk("R8 lower lane read", got_rdata, {16'h0, rd_model(5'h13, 5'd12)});
  endtask

  task automatic t_settle();
    int gap;
    lat = 0;
    do_req(1'b0, 1'b1, mkaddr(9'd9, 3'd0, 5'd0), 32'h0);
    chk("R4 page plus two ops", log_n, 3);
    gap = log_cyc[1] - log_cyc[0];
    chk("R4 settle gap lower bound", {31'b0, (gap >= int'(N_SETTLE) + 1)}, 32'h1);
    chk("R4 settle gap upper bound", {31'b0, (gap <= int'(N_SETTLE) + 4)}, 32'h1);
  endtask

  task automatic t_error();
    lat = 1;
    inj_err_idx = 1;
    do_req(1'b0, 1'b1, mkaddr(9'd9, 3'd1, 5'd0), 32'h0);
    chk("R10 error on second op", {31'b0, got_err}, 32'h1);
    inj_err_idx = -1;
    do_req(1'b0, 1'b1, mkaddr(9'd9, 3'd1, 5'd0), 32'h0);
    chk("R10 error cleared next request", {31'b0, got_err}, 32'h0);
    inj_err_idx = 0;
    do_req(1'b1, 1'b0, mkaddr(9'd10, 3'd1, 5'd0), 32'h0000_5555);
    chk("R10 page op error", {31'b0, got_err}, 32'h1);
    chk("R10 page op then data op", log_n, 2);
    inj_err_idx = -1;
  endtask

  task automatic t_ack();
    do_req(1'b0, 1'b0, mkaddr(9'd10, 3'd2, 5'd1), 32'h0);
    chk("R11 no op during ack", {31'b0, ack_op_valid}, 32'h0);
    chk("R11 ack lasts one cycle", {31'b0, ack_after}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_lo_first = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_read_page0();
    t_same_page();
    t_wr_lo_first();
    t_wr_hi_first();
    t_narrow();
    t_settle();
    t_error();
    t_ack();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule